// File: doc/BRIEF.md
# Indexed Address Generator with Pre/Post Offset and Word-Size Scaling

This block generates addresses for one memory port of a processor. It holds a bank of index registers and a bank of modifier registers. Each access request names one index register and one offset. The offset is either a modifier register or a signed immediate that travels with the request. The request also picks one of two addressing modes. With the offset applied before the access, the block sends out index plus offset and leaves the index register as it was. With the offset applied after the access, the block sends out the index unchanged and then writes index plus offset back into the index register.

Before it leaves the block, the address is scaled by the access word size. Memory can then use it without any further translation. Software loads and inspects both banks through a simple register port. The scaled address and its valid flag come out of a register one cycle after the request.

Top module: `addr_gen_unit`

## Requirements
- R1: After reset, every index and modifier register reads zero, `addr_valid` is 0 and `addr_out` is 0.
- R2: With `reg_we` high, `reg_wdata` is written on the next clock edge into the register chosen by `reg_sel`. `reg_bank` picks the bank: 0 is the index bank and 1 is the modifier bank. `reg_rdata` always shows the register that `reg_bank`/`reg_sel` currently select, with no clock delay.
- R3: In pre-offset mode (`req_post`=0), the unscaled address is index + offset, and the index register is not changed.
- R4: In post-offset mode (`req_post`=1), the unscaled address is the current index value. On the next edge the index register becomes index + offset.
- R5: With `req_use_imm`=1 the offset is the 16-bit `req_imm` sign-extended to 32 bits. Otherwise the offset is the modifier register chosen by `req_msel`, read as two's complement. All sums wrap modulo 2^32.
- R6: `req_size` sets the scaling. Code 0 (short) shifts the address left by 1. Code 1 (normal) passes it through. Code 2 (long) shifts it right by 1, filling with zero and dropping bit 0. Code 3 acts as normal.
- R7: `addr_out` and `addr_valid` are registered. A request sampled on an edge gives `addr_valid`=1 and its address after that edge. A cycle with no request gives `addr_valid`=0, and `addr_out` keeps its last value.
- R8: A request in the cycle after a post-offset request on the same index register sees the updated value.
- R9: If a register-port write to an index register and a post-offset update of that same register fall on the same edge, the written data wins. If the two target different registers, both take effect.
- R10: A request reads register values from before any register-port write on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_bank | input | 1 | Bank select: 0 index, 1 modifier |
| reg_sel | input | 3 | Register number in the bank |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register contents |
| req_valid | input | 1 | Access request strobe |
| req_post | input | 1 | 1 = post-offset with write-back, 0 = pre-offset |
| req_isel | input | 3 | Index register used |
| req_msel | input | 3 | Modifier register used |
| req_use_imm | input | 1 | 1 = use immediate as offset |
| req_imm | input | 16 | Signed immediate offset |
| req_size | input | 2 | Word size: 0 short, 1 normal, 2 long, 3 normal |
| addr_valid | output | 1 | Address valid |
| addr_out | output | 32 | Scaled address |

## Verification
A wrong index value shows up in `addr_out` on the first request that uses that register after the fault. For a post-offset request, the wrong value appears one cycle after the request. It also shows on `reg_rdata` at once. A lost or misplaced write-back shows up only when the next request or read touches that index. For this reason, back-to-back requests on the same register, and reads taken right after each update, are the checks that expose it. Errors in scaling or sign extension are visible in the very next `addr_out`.

// File: rtl/agu_pkg.sv
package agu_pkg;
   localparam logic [1:0] SZ_SHORT  = 2'd0;
   localparam logic [1:0] SZ_NORMAL = 2'd1;
   localparam logic [1:0] SZ_LONG   = 2'd2;
   localparam logic       BANK_IDX  = 1'b0;
   localparam logic       BANK_MOD  = 1'b1;
endpackage

// File: rtl/agu_regbank.sv
module agu_regbank #(
   parameter int W = 32,
   parameter int N = 8,
   parameter bit HAS_UPD = 1'b1,
   localparam int SW = $clog2(N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SW-1:0]     wr_sel,
   input  logic [W-1:0]      wr_data,
   input  logic              upd_en,
   input  logic [SW-1:0]     upd_sel,
   input  logic [W-1:0]      upd_data,
   output logic [N-1:0][W-1:0] q
);
   genvar k;
   generate
      for (k = 0; k < N; k++) begin : g_ent
         logic hit_wr;
         logic hit_upd;
         assign hit_wr = wr_en && (wr_sel == SW'(k));
         if (HAS_UPD) begin : g_upd
            assign hit_upd = upd_en && (upd_sel == SW'(k));
         end else begin : g_noupd
            logic unused_upd;
            assign unused_upd = upd_en ^ (^upd_sel) ^ (^upd_data);
            assign hit_upd = 1'b0;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q[k] <= '0;
            else if (hit_wr) q[k] <= wr_data;
            else if (hit_upd) q[k] <= upd_data;
         end
      end
   endgenerate
endmodule

// File: rtl/agu_calc.sv
module agu_calc #(
   parameter int W = 32,
   parameter int IW = 16
) (
   input  logic          post,
   input  logic          use_imm,
   input  logic [W-1:0]  idx,
   input  logic [W-1:0]  mod,
   input  logic [IW-1:0] imm,
   output logic [W-1:0]  eff,
   output logic [W-1:0]  next_idx
);
   logic [W-1:0] offs;
   logic [W-1:0] sum;
   always_comb begin
      offs = use_imm ? {{(W-IW){imm[IW-1]}}, imm} : mod;
      sum = idx + offs;
      eff = post ? idx : sum;
      next_idx = sum;
   end
endmodule

// File: rtl/agu_scale.sv
module agu_scale #(
   parameter int W = 32
) (
   input  logic [1:0]   size,
   input  logic [W-1:0] a,
   output logic [W-1:0] y
);
   import agu_pkg::*;
   always_comb begin
      case (size)
         SZ_SHORT: y = {a[W-2:0], 1'b0};
         SZ_LONG:  y = {1'b0, a[W-1:1]};
         default:  y = a;
      endcase
   end
endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit #(
   parameter int AW = 32,
   parameter int NREG = 8,
   parameter int IMMW = 16,
   localparam int SELW = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_we,
   input  logic            reg_bank,
   input  logic [SELW-1:0] reg_sel,
   input  logic [AW-1:0]   reg_wdata,
   output logic [AW-1:0]   reg_rdata,
   input  logic            req_valid,
   input  logic            req_post,
   input  logic [SELW-1:0] req_isel,
   input  logic [SELW-1:0] req_msel,
   input  logic            req_use_imm,
   input  logic [IMMW-1:0] req_imm,
   input  logic [1:0]      req_size,
   output logic            addr_valid,
   output logic [AW-1:0]   addr_out
);
   import agu_pkg::*;

   generate
      if (NREG < 2 || (1 << SELW) != NREG) begin : g_bad_nreg
         $error("NREG must be a power of two, at least 2");
      end
      if (IMMW < 2 || IMMW >= AW) begin : g_bad_immw
         $error("IMMW must lie between 2 and AW-1");
      end
   endgenerate

   logic [NREG-1:0][AW-1:0] i_q;
   logic [NREG-1:0][AW-1:0] m_q;
   logic [AW-1:0] eff, next_idx, scaled;

   agu_regbank #(.W(AW), .N(NREG), .HAS_UPD(1'b1)) u_ibank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_we && reg_bank == BANK_IDX), .wr_sel(reg_sel), .wr_data(reg_wdata),
      .upd_en(req_valid && req_post), .upd_sel(req_isel), .upd_data(next_idx),
      .q(i_q));

   agu_regbank #(.W(AW), .N(NREG), .HAS_UPD(1'b0)) u_mbank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_we && reg_bank == BANK_MOD), .wr_sel(reg_sel), .wr_data(reg_wdata),
      .upd_en(1'b0), .upd_sel('0), .upd_data('0),
      .q(m_q));

   agu_calc #(.W(AW), .IW(IMMW)) u_calc (
      .post(req_post), .use_imm(req_use_imm),
      .idx(i_q[req_isel]), .mod(m_q[req_msel]), .imm(req_imm),
      .eff(eff), .next_idx(next_idx));

   agu_scale #(.W(AW)) u_scale (.size(req_size), .a(eff), .y(scaled));

   assign reg_rdata = (reg_bank == BANK_MOD) ? m_q[reg_sel] : i_q[reg_sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_valid <= 1'b0;
         addr_out   <= '0;
      end else begin
         addr_valid <= req_valid;
         if (req_valid) addr_out <= scaled;
      end
   end
endmodule

// File: rtl/addr_gen_unit_chk.sv
module addr_gen_unit_chk #(
   parameter int AW = 32,
   parameter int NREG = 8,
   parameter int IMMW = 16,
   localparam int SELW = $clog2(NREG)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            reg_we,
   input logic            reg_bank,
   input logic [SELW-1:0] reg_sel,
   input logic [AW-1:0]   reg_wdata,
   input logic            req_valid,
   input logic            req_post,
   input logic [SELW-1:0] req_isel,
   input logic            req_use_imm,
   input logic [IMMW-1:0] req_imm,
   input logic [1:0]      req_size,
   input logic            addr_valid,
   input logic [AW-1:0]   addr_out,
   input logic [NREG-1:0][AW-1:0] i_q
);
   a_r7_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> addr_valid);
   a_r7_valid_low: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !addr_valid);
   a_r3_pre_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_post && !reg_we) |=> $stable(i_q));
   a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && !reg_bank) |=> i_q[$past(reg_sel)] == $past(reg_wdata));
   a_r4_post_imm_update: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_post && req_use_imm && !(reg_we && !reg_bank && reg_sel == req_isel))
      |=> i_q[$past(req_isel)] == $past(i_q[req_isel] + {{(AW-IMMW){req_imm[IMMW-1]}}, req_imm}));
   a_r4_post_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_post && req_size == 2'd1) |=> addr_out == $past(i_q[req_isel]));
endmodule

bind addr_gen_unit addr_gen_unit_chk #(.AW(AW), .NREG(NREG), .IMMW(IMMW)) u_chk (.*);

// File: tb/sim_addr_gen_unit.sv
module sim_addr_gen_unit;
   logic clk = 0, rst_n = 0;
   logic reg_we = 0, reg_bank = 0;
   logic [2:0] reg_sel = 0;
   logic [31:0] reg_wdata = 0, reg_rdata;
   logic req_valid = 0, req_post = 0, req_use_imm = 0;
   logic [2:0] req_isel = 0, req_msel = 0;
   logic [15:0] req_imm = 0;
   logic [1:0] req_size = 2'd1;
   logic addr_valid;
   logic [31:0] addr_out;
   int checks = 0, errors = 0;

   always #5 clk = ~clk;

   addr_gen_unit u0 (.*);

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic bank, input logic [2:0] sel, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1; reg_bank = bank; reg_sel = sel; reg_wdata = d;
      @(posedge clk); #1;
      reg_we = 0;
   endtask

   task automatic rd(input logic bank, input logic [2:0] sel, output logic [31:0] v);
      reg_bank = bank; reg_sel = sel;
      #1 v = reg_rdata;
   endtask

   task automatic req(input logic post, input logic [2:0] isel, input logic [2:0] msel,
                      input logic use_imm, input logic [15:0] imm, input logic [1:0] size);
      @(negedge clk);
      req_valid = 1; req_post = post; req_isel = isel; req_msel = msel;
      req_use_imm = use_imm; req_imm = imm; req_size = size;
      @(posedge clk); #1;
      req_valid = 0;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      check("R1 valid", {31'd0, addr_valid}, 0);
      check("R1 addr", addr_out, 0);
      rd(0, 3, v); check("R1 I3", v, 0);
      rd(1, 5, v); check("R1 M5", v, 0);
   endtask

   task automatic t_regs;
      logic [31:0] v;
      wr(0, 0, 32'h100); wr(1, 0, 32'h4);
      rd(0, 0, v); check("R2 I0", v, 32'h100);
      rd(1, 0, v); check("R2 M0", v, 32'h4);
   endtask

   task automatic t_pre;
      logic [31:0] v;
      wr(0, 1, 32'h1000); wr(1, 1, 32'h10);
      req(0, 1, 1, 0, 0, 2'd1);
      check("R3 addr", addr_out, 32'h1010);
      check("R7 valid", {31'd0, addr_valid}, 1);
      rd(0, 1, v); check("R3 I1 kept", v, 32'h1000);
   endtask

   task automatic t_post;
      logic [31:0] v;
      wr(0, 7, 32'h2000); wr(1, 4, 32'hFFFF_FFF8);
      req(1, 7, 4, 0, 0, 2'd1);
      check("R4 addr", addr_out, 32'h2000);
      rd(0, 7, v); check("R4 R5 I7 updated", v, 32'h1FF8);
   endtask

   task automatic t_imm;
      req(0, 1, 0, 1, 16'h8000, 2'd1);
      check("R5 sext imm", addr_out, 32'hFFFF_9000);
      req(0, 1, 0, 1, 16'h0020, 2'd1);
      check("R5 pos imm", addr_out, 32'h1020);
   endtask

   task automatic t_size;
      wr(0, 2, 32'h40);
      req(0, 2, 0, 1, 16'd4, 2'd0); check("R6 short", addr_out, 32'h88);
      req(0, 2, 0, 1, 16'd4, 2'd2); check("R6 long", addr_out, 32'h22);
      req(0, 2, 0, 1, 16'd4, 2'd3); check("R6 code3", addr_out, 32'h44);
      req(0, 2, 0, 1, 16'd5, 2'd2); check("R6 long trunc", addr_out, 32'h22);
   endtask

   task automatic t_timing;
      req(0, 2, 0, 1, 16'd8, 2'd1);
      check("R7 addr", addr_out, 32'h48);
      @(posedge clk); #1;
      check("R7 idle valid", {31'd0, addr_valid}, 0);
      check("R7 idle hold", addr_out, 32'h48);
   endtask

   task automatic t_b2b;
      logic [31:0] v;
      wr(0, 3, 32'h10); wr(1, 2, 32'h4);
      @(negedge clk);
      req_valid = 1; req_post = 1; req_isel = 3; req_msel = 2; req_use_imm = 0; req_size = 2'd1;
      @(posedge clk); #1;
      check("R8 first", addr_out, 32'h10);
      @(posedge clk); #1;
      req_valid = 0;
      check("R8 second", addr_out, 32'h14);
      rd(0, 3, v); check("R8 I3", v, 32'h18);
   endtask

   task automatic t_conflict;
      logic [31:0] v;
      wr(0, 5, 32'h500);
      @(negedge clk);
      req_valid = 1; req_post = 1; req_isel = 5; req_use_imm = 1; req_imm = 16'd8; req_size = 2'd1;
      reg_we = 1; reg_bank = 0; reg_sel = 5; reg_wdata = 32'hABC;
      @(posedge clk); #1;
      req_valid = 0; reg_we = 0;
      check("R9 addr", addr_out, 32'h500);
      rd(0, 5, v); check("R9 write wins", v, 32'hABC);
      @(negedge clk);
      req_valid = 1; req_post = 1; req_isel = 5; req_use_imm = 1; req_imm = 16'd8;
      reg_we = 1; reg_bank = 0; reg_sel = 6; reg_wdata = 32'h66;
      @(posedge clk); #1;
      req_valid = 0; reg_we = 0;
      rd(0, 5, v); check("R9 I5 updated", v, 32'hAC4);
      rd(0, 6, v); check("R9 I6 written", v, 32'h66);
   endtask

   task automatic t_same_edge;
      logic [31:0] v;
      wr(1, 3, 32'h1);
      @(negedge clk);
      req_valid = 1; req_post = 0; req_isel = 0; req_msel = 3; req_use_imm = 0; req_size = 2'd1;
      reg_we = 1; reg_bank = 1; reg_sel = 3; reg_wdata = 32'h20;
      @(posedge clk); #1;
      req_valid = 0; reg_we = 0;
      check("R10 old M3 used", addr_out, 32'h101);
      rd(1, 3, v); check("R10 M3 new", v, 32'h20);
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 t_reset();
      @(negedge clk) rst_n = 1;
      t_regs();
      t_pre();
      t_post();
      t_imm();
      t_size();
      t_timing();
      t_b2b();
      t_conflict();
      t_same_edge();
      repeat (2) @(posedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule